// File: doc/BRIEF.md
# GPIO pin interrupt detector

This block qualifies the external levels of a 16-pin general purpose port and turns them into interrupt requests. Every pin whose direction bit marks it as an input and whose input-enable bit is set is sampled through a two-stage synchronizer. The sampled level is written into the pin's data bit, which the block brings out as `pin_level`. Pins that are outputs, or inputs that are not enabled, keep their data bit and their level request untouched.

Each pin raises a request according to three configuration bits. With `cfg_edge` clear the pin is level-sensitive: the request is active while the level differs from `cfg_polar`. With `cfg_edge` set the pin is edge-sensitive. `cfg_both` then selects either any change, or a single direction chosen by `cfg_polar`. An edge request is a single-cycle pulse.

The per-pin requests are ANDed with two independent masks and ORed together into two registered interrupt lines. Register storage and bus decoding belong to the surrounding port logic. This block receives the configuration and the masks as plain inputs.

Top module: `gpio_irq_detect`

## Requirements
- R1: A pin is sensed only when its bit in `cfg_dir` is 0 and its bit in `cfg_inen` is 1. For any other pin, `pin_level` and a level-mode request keep their values whatever `pin_in` does, and an edge-mode request stays 0. Bit i of every configuration and mask vector applies to pin i.
- R2: For a sensed pin, a new `pin_in` level appears on `pin_level` after three rising clock edges: two synchronizer stages, then the data bit.
- R3: With `cfg_edge`=1 and `cfg_both`=1, any change of a sensed pin's data bit raises its request, in the same cycle that `pin_level` changes.
- R4: With `cfg_edge`=1 and `cfg_both`=0, `cfg_polar`=0 requests on rising edges only and `cfg_polar`=1 requests on falling edges only. The opposite edge gives no request.
- R5: An edge request is high for exactly one clock cycle per detected edge, and stays low while the pin holds still.
- R6: With `cfg_edge`=0, the request of a sensed pin equals `pin_level` XOR `cfg_polar` (polar 0 means active high). It follows the level, and deasserts when the level returns to the polar value.
- R7: `irq_a` is the OR of (`irq_req` AND `mask_a`) and `irq_b` the OR of (`irq_req` AND `mask_b`), registered one cycle after `irq_req`.
- R8: A change of `mask_a` or `mask_b` alone is reflected on the matching interrupt output at the next rising clock edge, using the current requests.
- R9: Synchronous active-high `rst` clears the synchronizers, `pin_level`, `irq_req`, `irq_a` and `irq_b` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 16 | Asynchronous external pin levels |
| cfg_dir | input | 16 | 1 = pin is an output (not sensed) |
| cfg_inen | input | 16 | 1 = input buffer enabled |
| cfg_polar | input | 16 | Level: 1 = active low; single edge: 1 = falling |
| cfg_edge | input | 16 | 1 = edge-sensitive, 0 = level-sensitive |
| cfg_both | input | 16 | With edge mode, 1 = request on either edge |
| mask_a | input | 16 | Enable of each request onto `irq_a` |
| mask_b | input | 16 | Enable of each request onto `irq_b` |
| pin_level | output | 16 | Data bits written by sensed pins |
| irq_req | output | 16 | Per-pin interrupt requests |
| irq_a | output | 1 | Masked interrupt output A |
| irq_b | output | 1 | Masked interrupt output B |

## Verification
The edge properties rest on one assumption: an external pin holds each level for at least two clock cycles. Otherwise two pulses could run into one another, and the one-cycle width check would have nothing clean to measure. The stimulus changes `pin_in` only on falling clock edges and waits several cycles between changes. Configuration and masks change only while the pins are quiet, or under reset. Before every table vector the block is reset, so the state of unsensed pins is known to be zero.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Trigger behaviour selected per pin from its edge and both bits.
  typedef enum logic [1:0] {
    TRIG_LEVEL    = 2'd0,
    TRIG_EDGE_ONE = 2'd1,
    TRIG_EDGE_ANY = 2'd2
  } trig_mode_e;

  function automatic trig_mode_e pick_mode(input logic edge_b, input logic both_b);
    if (!edge_b)     return TRIG_LEVEL;
    else if (both_b) return TRIG_EDGE_ANY;
    else             return TRIG_EDGE_ONE;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pin inputs.
module gpio_sync #(
  parameter int PINS   = 16,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] async_in,
  output logic [PINS-1:0] sync_out
);

  localparam int LAST = STAGES - 1;

  logic [PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_pin_detect.sv
// One pin: data bit capture and request generation.
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic smp,
  input  logic dir_out,
  input  logic in_en,
  input  logic polar,
  input  logic edge_sel,
  input  logic both_sel,
  output logic level_q,
  output logic req_q
);

  trig_mode_e mode;
  logic       sensed;
  logic       rise;
  logic       fall;
  logic       next_req;

  assign mode   = pick_mode(edge_sel, both_sel);
  assign sensed = !dir_out && in_en;
  assign rise   = !level_q && smp;
  assign fall   = level_q && !smp;

  always_comb begin
    next_req = req_q;
    if (sensed) begin
      unique case (mode)
        TRIG_LEVEL:    next_req = smp ^ polar;
        TRIG_EDGE_ONE: next_req = polar ? fall : rise;
        TRIG_EDGE_ANY: next_req = rise || fall;
        default:       next_req = 1'b0;
      endcase
    end else if (mode != TRIG_LEVEL) begin
      next_req = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (sensed) level_q <= smp;
      req_q <= next_req;
    end
  end

endmodule

// File: rtl/gpio_irq_merge.sv
// Masks the request vector onto a set of registered interrupt lines.
module gpio_irq_merge #(
  parameter int PINS    = 16,
  parameter int NUM_OUT = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [PINS-1:0]               req,
  input  logic [NUM_OUT-1:0][PINS-1:0]  masks,
  output logic [NUM_OUT-1:0]            irq_q
);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq_q[k] <= 1'b0;
      else     irq_q[k] <= |(req & masks[k]);
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int PINS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] cfg_dir,
  input  logic [PINS-1:0] cfg_inen,
  input  logic [PINS-1:0] cfg_polar,
  input  logic [PINS-1:0] cfg_edge,
  input  logic [PINS-1:0] cfg_both,
  input  logic [PINS-1:0] mask_a,
  input  logic [PINS-1:0] mask_b,
  output logic [PINS-1:0] pin_level,
  output logic [PINS-1:0] irq_req,
  output logic            irq_a,
  output logic            irq_b
);

  localparam int NUM_OUT = 2;

  logic [PINS-1:0]              pin_sync;
  logic [NUM_OUT-1:0]           irq_lines;
  logic [NUM_OUT-1:0][PINS-1:0] mask_set;

  gpio_sync #(
    .PINS   (PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpio_pin_detect u_pin (
      .clk      (clk),
      .rst      (rst),
      .smp      (pin_sync[i]),
      .dir_out  (cfg_dir[i]),
      .in_en    (cfg_inen[i]),
      .polar    (cfg_polar[i]),
      .edge_sel (cfg_edge[i]),
      .both_sel (cfg_both[i]),
      .level_q  (pin_level[i]),
      .req_q    (irq_req[i])
    );
  end

  assign mask_set = {mask_b, mask_a};

  gpio_irq_merge #(
    .PINS    (PINS),
    .NUM_OUT (NUM_OUT)
  ) u_merge (
    .clk   (clk),
    .rst   (rst),
    .req   (irq_req),
    .masks (mask_set),
    .irq_q (irq_lines)
  );

  assign irq_a = irq_lines[0];
  assign irq_b = irq_lines[1];

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [PINS-1:0] pin_in,
  input logic [PINS-1:0] cfg_dir,
  input logic [PINS-1:0] cfg_inen,
  input logic [PINS-1:0] cfg_polar,
  input logic [PINS-1:0] cfg_edge,
  input logic [PINS-1:0] cfg_both,
  input logic [PINS-1:0] mask_a,
  input logic [PINS-1:0] mask_b,
  input logic [PINS-1:0] pin_level,
  input logic [PINS-1:0] irq_req,
  input logic            irq_a,
  input logic            irq_b
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_a && !irq_b && irq_req == '0 && pin_level == '0)); // R9

  AST_MASK_A_OFF: assert property (@(posedge clk) disable iff (rst)
    (mask_a == '0) |=> !irq_a); // R7

  AST_MASK_B_OFF: assert property (@(posedge clk) disable iff (rst)
    (mask_b == '0) |=> !irq_b); // R7

  for (genvar i = 0; i < PINS; i++) begin : g_pin_chk
    AST_UNSENSED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cfg_dir[i] || !cfg_inen[i]) |=> (pin_level[i] == $past(pin_level[i]))); // R1

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      (!cfg_dir[i] && cfg_inen[i] && !cfg_edge[i])
        |=> (irq_req[i] == (pin_level[i] ^ $past(cfg_polar[i])))); // R6

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
      (!cfg_dir[i] && cfg_inen[i] && cfg_edge[i])
        |=> (!irq_req[i] || (pin_level[i] != $past(pin_level[i])))); // R3
  end

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.PINS(PINS)) u_chk (.*);

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] cfg_dir = '0, cfg_inen = '0, cfg_polar = '0, cfg_edge = '0, cfg_both = '0;
  logic [W-1:0] mask_a = '0, mask_b = '0;
  logic [W-1:0] pin_level, irq_req;
  logic         irq_a, irq_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.PINS(W)) i_gpio_irq_detect (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .cfg_dir(cfg_dir), .cfg_inen(cfg_inen), .cfg_polar(cfg_polar),
    .cfg_edge(cfg_edge), .cfg_both(cfg_both),
    .mask_a(mask_a), .mask_b(mask_b),
    .pin_level(pin_level), .irq_req(irq_req), .irq_a(irq_a), .irq_b(irq_b)
  );

  typedef struct packed {
    logic [W-1:0] dir;
    logic [W-1:0] inen;
    logic [W-1:0] polar;
    logic [W-1:0] edg;
    logic [W-1:0] both;
    logic [W-1:0] ma;
    logic [W-1:0] mb;
    logic [W-1:0] p0;
    logic [W-1:0] p1;
    logic [W-1:0] exp_req;
    logic [W-1:0] exp_lvl;
    logic         exp_a;
    logic         exp_b;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    // both-edge on every pin
    '{16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0010, 16'h8001,
      16'h00FF, 16'h0F0F, 16'h0FF0, 16'h0F0F, 1'b1, 1'b0},
    // single edge: low byte rising, high byte falling
    '{16'h0000, 16'hFFFF, 16'hFF00, 16'hFFFF, 16'h0000, 16'h000F, 16'h0100,
      16'h0F0F, 16'hF0F0, 16'h0FF0, 16'hF0F0, 1'b0, 1'b1},
    // level: low byte active low, high byte active high
    '{16'h0000, 16'hFFFF, 16'h00FF, 16'h0000, 16'h0000, 16'hFFFF, 16'hF00F,
      16'h0000, 16'h0F0F, 16'h0FF0, 16'h0F0F, 1'b1, 1'b0},
    // sensing: only pins 8..11 are enabled inputs
    '{16'h00FF, 16'h0FFF, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hF0FF, 16'h0800,
      16'h0000, 16'hFFFF, 16'h0F00, 16'h0F00, 1'b0, 1'b1},
    // level mode with input buffer off on high byte
    '{16'h0000, 16'h00FF, 16'h0000, 16'h0000, 16'h0000, 16'hFF00, 16'h0001,
      16'h0000, 16'hFFFF, 16'h00FF, 16'h00FF, 1'b0, 1'b1},
    // mixed modes, both masks closed
    '{16'h0000, 16'hFFFF, 16'h00F0, 16'h00FF, 16'h000F, 16'h0000, 16'h0000,
      16'h00F0, 16'hFF0F, 16'hFFFF, 16'hFF0F, 1'b0, 1'b0}
  };
  localparam string TAGS [NV] = '{"R3", "R4", "R6", "R1", "R1", "R5"};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R9: reset dominates a configuration that would otherwise request
    @(negedge clk);
    cfg_inen = '1; pin_in = '1; mask_a = '1; mask_b = '1;
    step(4);
    chk("R9 level", pin_level, '0);
    chk("R9 req", irq_req, '0);
    chk("R9 irq", {15'd0, irq_a | irq_b}, '0);

    // Table walk: reset, settle on p0, move to p1, check
    for (int v = 0; v < NV; v++) begin
      rst = 1'b1;
      cfg_dir = VECS[v].dir; cfg_inen = VECS[v].inen; cfg_polar = VECS[v].polar;
      cfg_edge = VECS[v].edg; cfg_both = VECS[v].both;
      mask_a = VECS[v].ma; mask_b = VECS[v].mb;
      pin_in = VECS[v].p0;
      step(2);
      rst = 1'b0;
      step(5);
      pin_in = VECS[v].p1;
      step(3);
      chk($sformatf("R2 level v%0d", v), pin_level, VECS[v].exp_lvl);
      chk($sformatf("%s req v%0d", TAGS[v], v), irq_req, VECS[v].exp_req);
      step(1);
      chk($sformatf("R5 req after v%0d", v), irq_req, VECS[v].exp_req & ~VECS[v].edg);
      chk($sformatf("R7 irq_a v%0d", v), {15'd0, irq_a}, {15'd0, VECS[v].exp_a});
      chk($sformatf("R7 irq_b v%0d", v), {15'd0, irq_b}, {15'd0, VECS[v].exp_b});
    end

    // R8: mask change alone moves the output one edge later
    rst = 1'b1;
    cfg_dir = '0; cfg_inen = '1; cfg_polar = '0; cfg_edge = '0; cfg_both = '0;
    mask_a = '0; mask_b = '0; pin_in = 16'h0001;
    step(2);
    rst = 1'b0;
    step(6);
    chk("R6 req high", irq_req, 16'h0001);
    chk("R7 masked off", {15'd0, irq_a}, '0);
    mask_a = 16'h0001;
    step(1);
    chk("R8 mask_a on", {15'd0, irq_a}, 16'h0001);
    mask_a = 16'h0000;
    step(1);
    chk("R8 mask_a off", {15'd0, irq_a}, '0);
    mask_b = 16'h0001;
    step(1);
    chk("R8 mask_b on", {15'd0, irq_b}, 16'h0001);

    // R6: level request drops once the level returns to polar
    pin_in = 16'h0000;
    step(2);
    chk("R2 latency hold", irq_req, 16'h0001);
    step(1);
    chk("R6 req drop", irq_req, 16'h0000);

    // R1: pin turned to output keeps its data bit and level request
    pin_in = 16'h0001;
    step(4);
    chk("R6 req again", irq_req, 16'h0001);
    cfg_dir = 16'h0001;
    pin_in = 16'h0000;
    step(5);
    chk("R1 level held", pin_level, 16'h0001);
    chk("R1 req held", irq_req, 16'h0001);

    // R5 / R4: single rising edge, one pulse, falling ignored
    rst = 1'b1;
    cfg_dir = '0; cfg_inen = 16'h0001; cfg_polar = '0; cfg_edge = 16'h0001; cfg_both = '0;
    mask_a = '0; mask_b = '0; pin_in = '0;
    step(2);
    rst = 1'b0;
    step(5);
    pin_in = 16'h0001;
    step(3);
    chk("R4 rising pulse", irq_req, 16'h0001);
    step(1);
    chk("R5 pulse ends", irq_req, 16'h0000);
    step(4);
    chk("R5 stays low", irq_req, 16'h0000);
    pin_in = 16'h0000;
    step(3);
    chk("R4 falling ignored", irq_req, 16'h0000);
    chk("R2 falling level", pin_level, 16'h0000);

    finish_run();
  end

endmodule